// File: doc/BRIEF.md
# Fail-Safe Flash Image Update Sequencer

This block takes a new configuration image as a byte stream and stores it in the active image region of a serial configuration flash. It drives a simple command port toward a flash controller. That port carries three commands: sector erase, page program and status read. The multiboot header and the golden backup copy lie outside the active region, and the block never touches them.

The order of the writes is chosen so that the active region never holds a complete image start marker while the update is under way. The block first erases every sector of the active region. It then programs the image page by page, with the four bytes of the 32-bit sync word left in the erased state. Only after every other byte has landed does it program the sync word, as a separate four-byte command. If power is lost at any earlier moment, the boot logic finds no sync word in the active region and loads the golden copy.

The image enters through a valid/ready byte port with first-byte and last-byte markers. The block reports its progress on busy, done and error outputs.

Top module: `flash_image_updater`

## Requirements
- R1: A first-marked byte seen while idle, done or in error starts an update. The block then issues one erase command (op 2'b01) for each sector of the active region, in ascending address order, before any program command (op 2'b10).
- R2: No erase or program command, and no programmed byte, ever addresses flash outside [ACT_BASE, ACT_BASE + SECTOR*ACT_SECTORS).
- R3: After each erase or program command, the block sends status commands (op 2'b11) and waits for each reply. It keeps doing so until a reply reports busy low, and it issues no other command before that.
- R4: Image bytes are programmed in order, one program command per PAGE bytes. Page n goes to ACT_BASE + n*PAGE. The final page carries the remaining bytes, and fl_wr_last marks the last byte of each command.
- R5: The block looks for the sync word 0xAA995566 (first byte 0xAA) within the first SEARCH bytes of the image. During the main pass the four sync bytes are sent as 0xFF, so the flash holds 0xFFFFFFFF there until the final command.
- R6: The last non-status command of a successful update programs exactly four bytes, 0xAA, 0x99, 0x55, 0x66, at ACT_BASE plus the byte offset of the sync word. The region then holds the whole image, and every byte past the image reads 0xFF.
- R7: If no sync word appears in the search window, error rises. No program command is issued and done stays low.
- R8: If the image is longer than the active region, error rises when the first excess byte arrives. The sync word is never programmed and done stays low.
- R9: Done rises only after the status poll that follows the sync-word program reports idle. Busy is high from the start of an update until done or error, and reset clears busy, done and error.
- R10: img_ready is high only while the block is collecting a page. It stays low during erase, page program and status polling.
- R11: A new update started after done or error clears both flags and runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| img_valid | input | 1 | Image byte valid |
| img_ready | output | 1 | Block accepts an image byte |
| img_data | input | 8 | Image byte |
| img_first | input | 1 | First byte of an image (starts an update) |
| img_last | input | 1 | Last byte of the image |
| fl_cmd_valid | output | 1 | Flash command valid |
| fl_cmd_ready | input | 1 | Flash command accepted |
| fl_cmd_op | output | 2 | 01 erase sector, 10 program, 11 read status |
| fl_cmd_addr | output | AW | Byte address of the command |
| fl_wr_valid | output | 1 | Program data byte valid (one per cycle after a program command) |
| fl_wr_data | output | 8 | Program data byte |
| fl_wr_last | output | 1 | Last data byte of the program command |
| fl_st_valid | input | 1 | Status reply valid |
| fl_st_busy | input | 1 | Flash write in progress |
| busy | output | 1 | Update in progress |
| done | output | 1 | Update committed |
| error | output | 1 | Update aborted |

## Verification
Three events can land on a single input byte: the sync-word match completes, page 0 fills, and the image ends. The handoff from collecting to programming must then see the match already recorded, and the main-pass data must still blank the last four bytes of the page. This case is set up with a 256-byte image whose sync word sits at offset 252, sent while the flash stalls command acceptance on alternate cycles. It is judged from the flash model's contents and command log: page 0 must be programmed with 0xFF at offsets 252 to 255, and one four-byte commit to offset 252 must follow, with nothing issued after it.

// File: rtl/flu_pkg.sv
`timescale 1ns/1ps
package flu_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_PROG   = 2'd2,
    OP_STATUS = 2'd3
  } flash_op_e;

  localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;

  typedef enum logic [3:0] {
    S_IDLE, S_ERASE, S_POLL, S_WAIT, S_RECV, S_CHECK,
    S_PROG, S_DATA, S_SYNC, S_SDATA, S_DONE, S_ERR
  } seq_state_e;
endpackage

// File: rtl/flu_sync_find.sv
`timescale 1ns/1ps
module flu_sync_find
  import flu_pkg::*;
#(
  parameter int IW     = 17,
  parameter int SEARCH = 256,
  localparam int OW    = $clog2(SEARCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          vld,
  input  logic [7:0]    data,
  input  logic [IW-1:0] idx,
  output logic          found,
  output logic [OW-1:0] offset
);
  logic [23:0] hist;
  logic        hit;

  // idx is the position of the byte that completes the word
  assign hit = vld && !found && (idx >= IW'(3)) && (idx < IW'(SEARCH)) &&
               ({hist, data} == SYNC_WORD);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hist   <= '0;
      found  <= 1'b0;
      offset <= '0;
    end else begin
      if (vld) hist <= {hist[15:0], data};
      if (hit) begin
        found  <= 1'b1;
        offset <= OW'(idx - IW'(3));
      end
    end
  end

  // R5: the first match in the window is kept for the rest of the update
  p_match_held_r5: assert property (@(posedge clk) disable iff (rst)
    (found && !clear) |=> (found && $stable(offset)));
endmodule

// File: rtl/flu_page_buf.sv
`timescale 1ns/1ps
module flu_page_buf #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_image_updater.sv
`timescale 1ns/1ps
module flash_image_updater
  import flu_pkg::*;
#(
  parameter int AW          = 24,
  parameter int PAGE        = 256,
  parameter int SECTOR      = 4096,
  parameter int ACT_SECTORS = 16,
  parameter logic [AW-1:0] ACT_BASE = 24'h10_0000,
  parameter int SEARCH      = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          img_valid,
  output logic          img_ready,
  input  logic [7:0]    img_data,
  input  logic          img_first,
  input  logic          img_last,
  output logic          fl_cmd_valid,
  input  logic          fl_cmd_ready,
  output logic [1:0]    fl_cmd_op,
  output logic [AW-1:0] fl_cmd_addr,
  output logic          fl_wr_valid,
  output logic [7:0]    fl_wr_data,
  output logic          fl_wr_last,
  input  logic          fl_st_valid,
  input  logic          fl_st_busy,
  output logic          busy,
  output logic          done,
  output logic          error
);
  localparam int REGION = SECTOR * ACT_SECTORS;
  localparam int NPAGES = REGION / PAGE;
  localparam int PW     = $clog2(PAGE);
  localparam int PGW    = PW + 1;
  localparam int IW     = $clog2(REGION) + 1;
  localparam int SW     = $clog2(ACT_SECTORS + 1);
  localparam int PIW    = $clog2(NPAGES + 1);
  localparam int OW     = $clog2(SEARCH);

  seq_state_e     st, ret;
  logic [SW-1:0]  sec_idx;
  logic [PIW-1:0] page_idx;
  logic [PGW-1:0] pg_cnt, rd_idx, rd_pos;
  logic [IW-1:0]  img_cnt;
  logic           last_seen, rd_vld, patch, sync_done;
  logic [1:0]     sk;
  logic [7:0]     mem_q, sync_byte;
  logic           found;
  logic [OW-1:0]  sync_off;
  flash_op_e      cmd_op;

  logic start, room, buf_we;
  assign start  = img_valid && img_first && (st == S_IDLE || st == S_DONE || st == S_ERR);
  assign room   = (img_cnt != IW'(REGION));
  assign buf_we = (st == S_RECV) && img_valid && room;
  assign img_ready = (st == S_RECV);

  flu_sync_find #(.IW(IW), .SEARCH(SEARCH)) u_find (
    .clk(clk), .rst(rst), .clear(start), .vld(buf_we), .data(img_data),
    .idx(img_cnt), .found(found), .offset(sync_off)
  );

  flu_page_buf #(.DEPTH(PAGE), .DW(8)) u_buf (
    .clk(clk), .we(buf_we), .waddr(pg_cnt[PW-1:0]), .wdata(img_data),
    .raddr(rd_idx[PW-1:0]), .rdata(mem_q)
  );

  // command decode from registered state
  always_comb begin
    fl_cmd_valid = 1'b0;
    cmd_op       = OP_IDLE;
    fl_cmd_addr  = '0;
    case (st)
      S_ERASE: begin
        fl_cmd_valid = 1'b1;
        cmd_op       = OP_ERASE;
        fl_cmd_addr  = ACT_BASE + AW'(sec_idx) * AW'(SECTOR);
      end
      S_PROG: begin
        fl_cmd_valid = 1'b1;
        cmd_op       = OP_PROG;
        fl_cmd_addr  = ACT_BASE + AW'(page_idx) * AW'(PAGE);
      end
      S_SYNC: begin
        fl_cmd_valid = 1'b1;
        cmd_op       = OP_PROG;
        fl_cmd_addr  = ACT_BASE + AW'(sync_off);
      end
      S_POLL: begin
        fl_cmd_valid = 1'b1;
        cmd_op       = OP_STATUS;
      end
      default: ;
    endcase
  end
  assign fl_cmd_op = cmd_op;

  always_comb begin
    case (sk)
      2'd0:    sync_byte = SYNC_WORD[31:24];
      2'd1:    sync_byte = SYNC_WORD[23:16];
      2'd2:    sync_byte = SYNC_WORD[15:8];
      default: sync_byte = SYNC_WORD[7:0];
    endcase
  end

  assign fl_wr_valid = rd_vld || (st == S_SDATA);
  assign fl_wr_data  = (st == S_SDATA) ? sync_byte : (patch ? 8'hFF : mem_q);
  assign fl_wr_last  = (rd_vld && rd_pos == pg_cnt - PGW'(1)) ||
                       (st == S_SDATA && sk == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ret <= S_IDLE;
      sec_idx <= '0; page_idx <= '0; pg_cnt <= '0; img_cnt <= '0;
      rd_idx <= '0; rd_pos <= '0; rd_vld <= 1'b0; patch <= 1'b0;
      last_seen <= 1'b0; sync_done <= 1'b0; sk <= '0;
      busy <= 1'b0; done <= 1'b0; error <= 1'b0;
    end else begin
      rd_vld <= 1'b0;
      case (st)
        S_IDLE, S_DONE, S_ERR: if (start) begin
          st <= S_ERASE;
          sec_idx <= '0; page_idx <= '0; pg_cnt <= '0; img_cnt <= '0;
          last_seen <= 1'b0; sync_done <= 1'b0;
          busy <= 1'b1; done <= 1'b0; error <= 1'b0;
        end
        S_ERASE: if (fl_cmd_ready) begin
          sec_idx <= sec_idx + SW'(1);
          ret <= (sec_idx == SW'(ACT_SECTORS - 1)) ? S_RECV : S_ERASE;
          st  <= S_POLL;
        end
        S_POLL: if (fl_cmd_ready) st <= S_WAIT;
        S_WAIT: if (fl_st_valid) begin
          if (fl_st_busy) st <= S_POLL;
          else begin
            st <= ret;
            if (ret == S_DONE) begin
              done <= 1'b1;
              busy <= 1'b0;
            end
          end
        end
        S_RECV: if (img_valid) begin
          if (!room) begin
            st <= S_ERR; error <= 1'b1; busy <= 1'b0;
          end else begin
            pg_cnt  <= pg_cnt + PGW'(1);
            img_cnt <= img_cnt + IW'(1);
            if (img_last || pg_cnt == PGW'(PAGE - 1)) begin
              st <= S_CHECK;
              last_seen <= img_last;
            end
          end
        end
        S_CHECK: begin
          if (!found) begin
            st <= S_ERR; error <= 1'b1; busy <= 1'b0;
          end else st <= S_PROG;
        end
        S_PROG: if (fl_cmd_ready) begin
          st <= S_DATA;
          rd_idx <= '0;
        end
        S_DATA: begin
          if (rd_idx < pg_cnt) begin
            rd_vld <= 1'b1;
            rd_idx <= rd_idx + PGW'(1);
            rd_pos <= rd_idx;
            patch  <= (page_idx == '0) && (rd_idx >= PGW'(sync_off)) &&
                      (rd_idx < PGW'(sync_off) + PGW'(4));
          end
          if (rd_vld && rd_pos == pg_cnt - PGW'(1)) begin
            st <= S_POLL;
            page_idx <= page_idx + PIW'(1);
            pg_cnt <= '0;
            ret <= last_seen ? S_SYNC : S_RECV;
          end
        end
        S_SYNC: if (fl_cmd_ready) begin
          st <= S_SDATA;
          sk <= '0;
        end
        S_SDATA: begin
          sk <= sk + 2'd1;
          if (sk == 2'd3) begin
            st <= S_POLL;
            ret <= S_DONE;
            sync_done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // write-in-progress tracker used only by the checks below
  logic wip_chk;
  always_ff @(posedge clk) begin
    if (rst) wip_chk <= 1'b0;
    else if (fl_cmd_valid && fl_cmd_ready && fl_cmd_op != OP_STATUS) wip_chk <= 1'b1;
    else if (fl_st_valid && !fl_st_busy) wip_chk <= 1'b0;
  end

  p_region_only_r2: assert property (@(posedge clk) disable iff (rst)
    (fl_cmd_valid && fl_cmd_op != OP_STATUS) |->
      (fl_cmd_addr >= ACT_BASE && fl_cmd_addr < ACT_BASE + AW'(REGION)));

  p_poll_before_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    (fl_cmd_valid && fl_cmd_op != OP_STATUS) |-> !wip_chk);

  p_erase_before_prog_r1: assert property (@(posedge clk) disable iff (rst)
    (fl_cmd_valid && fl_cmd_op == OP_PROG) |-> (sec_idx == SW'(ACT_SECTORS)));

  p_done_after_commit_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (sync_done && !error));

  p_error_no_commit_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> !sync_done);

  p_stall_input_r10: assert property (@(posedge clk) disable iff (rst)
    (fl_wr_valid || fl_cmd_valid) |-> !img_ready);
endmodule

// File: tb/flash_image_updater_test.sv
`timescale 1ns/1ps
module flash_image_updater_test;
  localparam int AW = 24, PAGE = 256, SECT = 256, NSECT = 4;
  localparam int BASE = 1024, REG = NSECT * SECT, FSIZE = 4096;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic img_valid = 1'b0, img_first = 1'b0, img_last = 1'b0;
  logic [7:0] img_data = 8'h00;
  logic img_ready, fl_cmd_valid, fl_cmd_ready, fl_wr_valid, fl_wr_last;
  logic [1:0] fl_cmd_op;
  logic [AW-1:0] fl_cmd_addr;
  logic [7:0] fl_wr_data;
  logic fl_st_valid = 1'b0, fl_st_busy = 1'b0;
  logic busy, done, error;

  flash_image_updater #(.AW(AW), .PAGE(PAGE), .SECTOR(SECT), .ACT_SECTORS(NSECT),
    .ACT_BASE(24'h000400), .SEARCH(256)) uut (
    .clk(clk), .rst(rst), .img_valid(img_valid), .img_ready(img_ready),
    .img_data(img_data), .img_first(img_first), .img_last(img_last),
    .fl_cmd_valid(fl_cmd_valid), .fl_cmd_ready(fl_cmd_ready), .fl_cmd_op(fl_cmd_op),
    .fl_cmd_addr(fl_cmd_addr), .fl_wr_valid(fl_wr_valid), .fl_wr_data(fl_wr_data),
    .fl_wr_last(fl_wr_last), .fl_st_valid(fl_st_valid), .fl_st_busy(fl_st_busy),
    .busy(busy), .done(done), .error(error));

  int vectors = 0, fails = 0;

  // flash model
  logic mclr = 1'b0, stall = 1'b0, tog = 1'b0, wip = 1'b0;
  logic [7:0] fmem [FSIZE];
  logic [7:0] img [2048];
  int nerase, nprog, bad_wip, bad_addr, rdy_bad, busy_left, cur, exp_sync;
  int er_addr [8];
  int pr_addr [16];
  int pr_len [16];
  logic [31:0] snap;

  assign fl_cmd_ready = stall ? tog : 1'b1;

  always @(posedge clk) begin
    fl_st_valid <= 1'b0;
    tog <= ~tog;
    if (mclr) begin
      nerase = 0; nprog = 0; bad_wip = 0; bad_addr = 0; rdy_bad = 0;
      busy_left = 0; cur = 0; wip = 1'b0; snap = 32'h0;
      for (int i = 0; i < FSIZE; i++) fmem[i] = 8'h5A;
    end else begin
      if (img_ready && (fl_wr_valid || fl_cmd_valid)) rdy_bad++;
      if (fl_wr_valid) begin
        if (cur >= BASE && cur < BASE + REG) fmem[cur] = fmem[cur] & fl_wr_data;
        else bad_addr++;
        cur++;
        if (nprog > 0 && nprog <= 16) pr_len[nprog-1]++;
      end
      if (fl_cmd_valid && fl_cmd_ready) begin
        int a;
        a = int'(fl_cmd_addr);
        case (fl_cmd_op)
          2'd1: begin
            if (wip) bad_wip++;
            if (a < BASE || a >= BASE + REG || (a % SECT) != 0) bad_addr++;
            else for (int j = 0; j < SECT; j++) fmem[a+j] = 8'hFF;
            if (nerase < 8) er_addr[nerase] = a;
            nerase++;
            wip = 1'b1; busy_left = 2;
          end
          2'd2: begin
            if (wip) bad_wip++;
            if (a < BASE || a >= BASE + REG) bad_addr++;
            if (a == exp_sync)
              snap = {fmem[a], fmem[a+1], fmem[a+2], fmem[a+3]};
            if (nprog < 16) begin pr_addr[nprog] = a; pr_len[nprog] = 0; end
            nprog++;
            cur = a;
            wip = 1'b1; busy_left = 2;
          end
          2'd3: begin
            fl_st_valid <= 1'b1;
            fl_st_busy  <= (busy_left != 0);
            if (busy_left != 0) busy_left--;
            else wip = 1'b0;
          end
          default: bad_addr++;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic build(input int len, input int off);
    for (int i = 0; i < len; i++) img[i] = 8'(i * 5 + 1);
    if (off >= 0) begin
      img[off] = 8'hAA; img[off+1] = 8'h99; img[off+2] = 8'h55; img[off+3] = 8'h66;
      exp_sync = BASE + off;
    end else exp_sync = -100;
  endtask

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      img_valid = 1'b1; img_data = img[i];
      img_first = (i == 0); img_last = (i == len - 1);
      if (i == 0) while (!busy) @(negedge clk);
      while (!img_ready && !error) @(negedge clk);
      if (error) break;
      @(negedge clk);
    end
    img_valid = 1'b0; img_first = 1'b0; img_last = 1'b0;
  endtask

  task automatic run(input int len, input int off, input logic stl);
    build(len, off);
    stall = stl;
    @(negedge clk) mclr = 1'b1;
    @(negedge clk) mclr = 1'b0;
    send(len);
    while (!(done || error)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic content(input int len, input int off, output int m_in, output int m_out);
    m_in = 0; m_out = 0;
    for (int a = 0; a < FSIZE; a++) begin
      logic [7:0] e;
      if (a >= BASE && a < BASE + REG) begin
        e = (a - BASE < len) ? img[a-BASE] : 8'hFF;
        if (off < 0 && a - BASE < 4) e = 8'hFF;
        if (fmem[a] !== e) m_in++;
      end else if (fmem[a] !== 8'h5A) m_out++;
    end
  endtask

  task automatic check_good(input int len, input int off, input string tag);
    int np, mi, mo;
    np = (len + PAGE - 1) / PAGE;
    chk({tag, " R9 done"}, int'(done), 1);
    chk({tag, " R9 busy low"}, int'(busy), 0);
    chk({tag, " R11 error clear"}, int'(error), 0);
    chk({tag, " R1 erase count"}, nerase, NSECT);
    for (int k = 0; k < NSECT; k++) chk({tag, " R1 erase addr"}, er_addr[k], BASE + k * SECT);
    chk({tag, " R3 command while busy"}, bad_wip, 0);
    chk({tag, " R2 out-of-region access"}, bad_addr, 0);
    chk({tag, " R10 ready during flash work"}, rdy_bad, 0);
    chk({tag, " R4 program count"}, nprog, np + 1);
    for (int k = 0; k < np; k++) begin
      chk({tag, " R4 page addr"}, pr_addr[k], BASE + k * PAGE);
      chk({tag, " R4 page len"}, pr_len[k], (k == np - 1) ? len - k * PAGE : PAGE);
    end
    chk({tag, " R5 sync blank before commit"}, int'(snap), 32'hFFFF_FFFF);
    chk({tag, " R6 commit addr"}, pr_addr[np], BASE + off);
    chk({tag, " R6 commit len"}, pr_len[np], 4);
    content(len, off, mi, mo);
    chk({tag, " R6 region content"}, mi, 0);
    chk({tag, " R2 outside untouched"}, mo, 0);
  endtask

  task automatic t_reset;
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset error", int'(error), 0);
    chk("R10 reset ready", int'(img_ready), 0);
    chk("R1 reset no command", int'(fl_cmd_valid), 0);
  endtask

  task automatic t_basic;
    run(600, 20, 1'b0);
    check_good(600, 20, "basic");
  endtask

  task automatic t_nosync;
    run(300, -1, 1'b0);
    chk("R7 error set", int'(error), 1);
    chk("R7 done low", int'(done), 0);
    chk("R7 no program", nprog, 0);
    chk("R7 busy low", int'(busy), 0);
  endtask

  task automatic t_boundary;
    // match, page fill and image end on byte 255, with command stalls
    run(256, 252, 1'b1);
    check_good(256, 252, "boundary R11");
  endtask

  task automatic t_overflow;
    int mi, mo;
    run(1100, 0, 1'b0);
    chk("R8 error set", int'(error), 1);
    chk("R8 done low", int'(done), 0);
    chk("R8 pages only", nprog, NSECT * SECT / PAGE);
    chk("R8 last command full page", pr_len[nprog-1], PAGE);
    content(REG, -1, mi, mo);
    chk("R8 sync stays blank", mi, 0);
    chk("R2 overflow outside untouched", mo, 0);
    chk("R2 overflow addr", bad_addr, 0);
  endtask

  task automatic t_restart;
    run(700, 100, 1'b0);
    check_good(700, 100, "restart R11");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_basic;
    t_nosync;
    t_boundary;
    t_overflow;
    t_restart;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule